// File: doc/BRIEF.md
# Ethernet Jack LED Status Driver

This block drives the two bi-color lamps on an Ethernet jack. One lamp shows link speed, the other shows traffic. Each lamp is a two-wire pair `{grn, yel}`, so it can be off, green or yellow. The speed comes from the MAC as a 2-bit code. Some MAC interface modes carry no speed information, and for those a static configuration input forces the speed lamp to a fixed indication, which is 100 Mbit/s by default.

Transmit and receive activity pulses light the activity lamp yellow. The lamp is held on by a stretch timer of 2^`STRETCH_W` clock cycles, so that a single-cycle pulse is still visible. When the link is down, both lamps are dark. Both outputs are registered and follow their inputs one clock edge later.

Top module: `eth_led_status`

## Requirements
- R1: With the link up and the speed not forced, the speed lamp follows `speed_code` one cycle later. Code 2'b00 (10 Mbit/s) gives off (2'b00). Code 2'b01 (100 Mbit/s) gives yellow (`{grn,yel}`=2'b01). Code 2'b10 (1 Gbit/s) gives green (2'b10). Code 2'b11 gives off.
- R2: With the link up and `speed_fixed_en` high, the speed lamp shows the fixed value one cycle later, whatever `speed_code` is. The default fixed value is 100 Mbit/s (yellow, 2'b01).
- R3: The activity lamp never shows green: `act_led[1]` is always 0.
- R4: With the link up, a cycle with `act_tx` or `act_rx` high turns the activity lamp yellow (2'b01) from the next cycle. The lamp stays yellow for exactly 2^`STRETCH_W` cycles and then goes off.
- R5: A new activity pulse inside the lit window restarts the full stretch time, counted from that pulse.
- R6: A cycle with `link_up` low turns both lamps off from the next cycle and clears the stretch timer. Activity pulses seen while the link is down light nothing, either then or after the link returns.
- R7: A cycle with `rst` high turns both lamps off from the next cycle and clears the stretch timer.
- R8: Neither lamp pair ever has both bits high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| link_up | input | 1 | Link established flag |
| speed_code | input | 2 | Speed from the MAC: 00=10M, 01=100M, 10=1G, 11=none |
| speed_fixed_en | input | 1 | Forces the speed lamp to the fixed value |
| act_tx | input | 1 | Transmit activity pulse |
| act_rx | input | 1 | Receive activity pulse |
| spd_led | output | 2 | Speed lamp `{grn,yel}` |
| act_led | output | 2 | Activity lamp `{grn,yel}` |

## Verification
On every cycle, the assertions check the following:
- both lamps go dark after reset or after a link drop;
- the speed override wins over the speed code;
- a gigabit code gives green;
- a pulse lights the activity lamp on the next cycle;
- neither pair ever has two bits lit.

Some behaviours cover a span of many cycles, and only the bench scenarios show them:
- the exact length of the stretch window;
- the restart of the window by a late pulse;
- the fact that pulses seen while the link is down leave no trace once it returns.

// File: rtl/eth_led_status.sv
module eth_led_status #(
  parameter int          STRETCH_W  = 22,
  parameter logic [1:0]  FIXED_CODE = 2'b01
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       link_up,
  input  logic [1:0] speed_code,
  input  logic       speed_fixed_en,
  input  logic       act_tx,
  input  logic       act_rx,
  output logic [1:0] spd_led,
  output logic [1:0] act_led
);

  localparam int CW = STRETCH_W + 1;
  localparam logic [CW-1:0] STRETCH = {1'b1, {STRETCH_W{1'b0}}};

  localparam logic [1:0] LAMP_OFF = 2'b00;
  localparam logic [1:0] LAMP_YEL = 2'b01;
  localparam logic [1:0] LAMP_GRN = 2'b10;

  function automatic logic [1:0] speed_lamp(input logic [1:0] code);
    case (code)
      2'b01:   speed_lamp = LAMP_YEL;
      2'b10:   speed_lamp = LAMP_GRN;
      default: speed_lamp = LAMP_OFF;
    endcase
  endfunction

  logic [CW-1:0] hold_cnt;
  logic [1:0]    spd_q;
  logic          pulse;

  assign pulse = act_tx | act_rx;

  always_ff @(posedge clk) begin
    if (rst || !link_up)
      hold_cnt <= '0;
    else if (pulse)
      hold_cnt <= STRETCH;
    else if (hold_cnt != '0)
      hold_cnt <= hold_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !link_up)
      spd_q <= LAMP_OFF;
    else
      spd_q <= speed_lamp(speed_fixed_en ? FIXED_CODE : speed_code);
  end

  assign spd_led = spd_q;
  assign act_led = (hold_cnt != '0) ? LAMP_YEL : LAMP_OFF;

  AST_RESET_DARK: assert property (@(posedge clk)
    rst |=> (spd_led == LAMP_OFF && act_led == LAMP_OFF)); // R7

  AST_LINK_DOWN_DARK: assert property (@(posedge clk) disable iff (rst)
    !link_up |=> (spd_led == LAMP_OFF && act_led == LAMP_OFF)); // R6

  AST_FORCED_SPEED: assert property (@(posedge clk) disable iff (rst)
    (link_up && speed_fixed_en) |=> spd_led == speed_lamp(FIXED_CODE)); // R2

  AST_GIGA_GREEN: assert property (@(posedge clk) disable iff (rst)
    (link_up && !speed_fixed_en && speed_code == 2'b10) |=> spd_led == LAMP_GRN); // R1

  AST_PULSE_LIGHTS: assert property (@(posedge clk) disable iff (rst)
    (link_up && pulse) |=> act_led == LAMP_YEL); // R4

  AST_PAIRS_SINGLE: assert property (@(posedge clk)
    $onehot0(spd_led) && $onehot0(act_led)); // R8

endmodule

// File: tb/sim_eth_led_status.sv
module sim_eth_led_status;
  localparam int PERIOD = 10;
  localparam int SW     = 4;
  localparam int WIN    = 1 << SW;

  logic clk = 0, rst = 1, link_up = 0, fix = 0, tx = 0, rx = 0;
  logic [1:0] code = 0;
  logic [1:0] spd_led, act_led;

  int checks = 0, fails = 0, ecnt = 0;
  logic [1:0] espd = 0;
  bit done = 0;

  eth_led_status #(.STRETCH_W(SW)) u0 (
    .clk(clk), .rst(rst), .link_up(link_up), .speed_code(code),
    .speed_fixed_en(fix), .act_tx(tx), .act_rx(rx),
    .spd_led(spd_led), .act_led(act_led));

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [1:0] lamp_of(input logic [1:0] c);
    return (c == 2'b01) ? 2'b01 : (c == 2'b10) ? 2'b10 : 2'b00;
  endfunction

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    if (rst || !link_up) begin ecnt = 0; espd = 2'b00; end
    else begin
      if (tx || rx) ecnt = WIN; else if (ecnt > 0) ecnt--;
      espd = fix ? 2'b01 : lamp_of(code);
    end
    @(negedge clk);
    chk(rst ? "R7" : !link_up ? "R6" : fix ? "R2" : "R1", spd_led, espd);
    chk("R4", act_led, (ecnt > 0) ? 2'b01 : 2'b00);
    chk("R3", {1'b0, act_led[1]}, 2'b00);
    chk("R8", {1'b0, spd_led[1] & spd_led[0]}, 2'b00);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin tx = 0; rx = 0; step(); end
  endtask

  initial begin
    int lit;
    void'($urandom(32'd1234));
    @(negedge clk);
    rst = 1; link_up = 1; code = 2'b10; tx = 1;
    step();
    chk("R7", {spd_led, act_led}, 4'b0000);
    rst = 0; tx = 0;

    for (int c = 0; c < 4; c++) begin
      code = c[1:0]; fix = 0; step();
      chk("R1", spd_led, lamp_of(c[1:0]));
      fix = 1; step();
      chk("R2", spd_led, 2'b01);
    end
    fix = 0;

    tx = 1; step(); tx = 0; lit = 1;
    while (act_led == 2'b01 && lit < 3 * WIN) begin step(); if (act_led == 2'b01) lit++; end
    checks++; if (lit != WIN) begin fails++; $display("FAIL R4: lit %0d expected %0d", lit, WIN); end

    rx = 1; step(); rx = 0; idle(WIN - 3);
    rx = 1; step(); rx = 0; lit = 1;
    while (act_led == 2'b01 && lit < 3 * WIN) begin step(); if (act_led == 2'b01) lit++; end
    checks++; if (lit != WIN) begin fails++; $display("FAIL R5: lit %0d expected %0d", lit, WIN); end

    tx = 1; step(); tx = 0; link_up = 0; step();
    chk("R6", act_led, 2'b00);
    tx = 1; step(); tx = 0; link_up = 1; step();
    chk("R6", act_led, 2'b00);

    for (int i = 0; i < 3000; i++) begin
      rst     = ($urandom_range(0, 199) == 0);
      link_up = ($urandom_range(0, 19) != 0);
      fix     = ($urandom_range(0, 3) == 0);
      code    = 2'($urandom_range(0, 3));
      tx      = ($urandom_range(0, 29) == 0);
      rx      = ($urandom_range(0, 29) == 0);
      step();
    end
    rst = 0; idle(2);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule